// File: doc/BRIEF.md
# Parallel Port Peripheral Receiver

This block sits on the peripheral side of a Centronics-style parallel link and receives bytes in compatibility mode. It watches the host's strobe and select-in lines through a synchronizer. When it sees a strobe falling edge with select-in low, it latches the 8-bit data bus into a receive register. It then tells the local processor or DMA engine through a request flag, and answers the host with the Busy / nAck acknowledge pair. The width of the nAck pulse is set by a timing register, counted in system clocks.

The local side reads and writes a small register file. The file holds the receive and transmit data, a per-pin direction mask, the three peripheral status outputs and the acknowledge width. A read-only status word reports the synchronized nAutoFd level, the idle flag and the request flag. While the block is enabled and select-in is low, every data pin is forced to input. Otherwise the direction mask decides which pins are driven.

Busy stays high until the local side has drained the byte. If the byte has not been read when the acknowledge pulse ends, the idle flag is raised. A later read of the data register then releases Busy.

Top module: `pp_rx_periph`

## Requirements
- R1: With modeEn high and synchronized selectInN low, padDataOe is 8'h00. Otherwise padDataOe equals the direction register (address 1, bit=1 drives the pin). padDataOut equals the last byte written to address 0. selectInN reaches padDataOe two clocks after it is sampled.
- R2: With modeEn high, a capture happens when the synchronized strobeN falls while synchronized selectInN is low and dreq is clear. On that clock edge, padDataIn is stored (readable at address 0), dreq goes high and busy goes high.
- R3: Once set, dreq stays high until a read of address 0 (regRd with regAddr=0), which clears it at that clock edge.
- R4: ackN goes low on the clock edge after the one on which busy rises. ackN is never low while busy is low.
- R5: ackN stays low for exactly N clocks, where N is the timing register at address 3, and a value of 0 is treated as 1. The reset value is 25.
- R6: On the clock after ackN returns high, busy goes low if dreq is clear. Otherwise idle goes high and busy stays high.
- R7: While busy is being held with idle set, busy goes low and idle clears one clock after a read of address 0 has cleared dreq.
- R8: A strobe while dreq is set is ignored: the stored byte is not overwritten and no handshake starts.
- R9: A strobe while selectInN is high is ignored: dreq and busy stay low.
- R10: A single strobe low period captures at most one byte, however long it lasts.
- R11: The control register at address 2 drives the status pins: bit0 drives select, bit1 drives pError and bit2 drives faultN. Its reset value is 3'b100.
- R12: The status word at address 4 holds bit0 = synchronized autoFdN, bit1 = idle and bit2 = dreq. autoFdN has no effect on the handshake.
- R13: A rising edge of modeEn while dreq is set raises idle. While modeEn is low, busy is low, ackN is high and idle is clear, and dreq keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeEn | input | 1 | Enables the peripheral receive mode |
| strobeN | input | 1 | Host data strobe, active low, asynchronous |
| selectInN | input | 1 | Host select-in, low claims the data bus for the host |
| autoFdN | input | 1 | Host auto-feed line, status only |
| padDataIn | input | 8 | Data bus value seen at the pins |
| padDataOut | output | 8 | Value driven onto pins that are outputs |
| padDataOe | output | 8 | Per-pin output enable, 1 drives |
| busy | output | 1 | Busy line to host |
| ackN | output | 1 | Acknowledge line to host, active low |
| select | output | 1 | Select status to host |
| pError | output | 1 | Paper-error status to host |
| faultN | output | 1 | Fault status to host, active low |
| regWr | input | 1 | Local register write strobe |
| regRd | input | 1 | Local register read strobe |
| regAddr | input | 3 | Local register address |
| regWdata | input | 8 | Local write data |
| regRdata | output | 8 | Local read data, combinational |
| dreq | output | 1 | Byte-ready request to processor or DMA |
| idle | output | 1 | Handshake stalled waiting for a drain |

## Verification
The bench drives a strobe that stays low for many clocks and reads the byte in the middle of it. A design that detects the strobe level instead of its edge would capture the same byte a second time. It also strobes a second byte while the first is still unread, and strobes with select-in high. A receiver that gates wrongly would overwrite the byte or start a spurious acknowledge. The acknowledge width is measured for a programmed value and for zero, which catches a counter that is off by one or one that wraps on zero. It also covers the drain paths: reading before the acknowledge ends, reading after the idle stall, and leaving and re-entering the mode with a byte pending. A design that got these wrong would hold Busy forever, release it early, or miss the idle flag.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_TIME = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd4;

  // control register bit positions
  localparam int CTRL_SELECT = 0;
  localparam int CTRL_PERROR = 1;
  localparam int CTRL_FAULTN = 2;
  localparam int CTRL_W      = 3;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_DLY  = 3'd1,
    ST_ACK  = 3'd2,
    ST_REL  = 3'd3,
    ST_HOLD = 3'd4
  } hsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic forceIn;
  } dpStrobe_t;

endpackage

// File: rtl/pp_rx_sync.sv
module pp_rx_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RESET_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/pp_rx_ctrl.sv
module pp_rx_ctrl
  import pp_rx_pkg::*;
#(
  parameter int ACK_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeEn,
  input  logic             strobeSync,
  input  logic             selSync,
  input  logic             dreq,
  input  logic [ACK_W-1:0] ackWidth,
  output dpStrobe_t        stb,
  output logic             busy,
  output logic             ackN,
  output logic             idle
);

  hsState_t         state;
  logic [ACK_W-1:0] ackCnt;
  logic             strbPrev;
  logic             modePrev;
  logic             strobeFall;
  logic             modeRise;
  logic [ACK_W-1:0] ackLoad;

  assign strobeFall = strbPrev & ~strobeSync;
  assign modeRise   = modeEn & ~modePrev;
  assign ackLoad    = (ackWidth == '0) ? ACK_W'(1) : ackWidth;

  always_comb begin
    stb.capture = modeEn & strobeFall & ~selSync & ~dreq & (state == ST_WAIT);
    stb.forceIn = modeEn & ~selSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbPrev <= 1'b1;
      modePrev <= 1'b0;
    end else begin
      strbPrev <= strobeSync;
      modePrev <= modeEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_WAIT;
      busy   <= 1'b0;
      ackN   <= 1'b1;
      idle   <= 1'b0;
      ackCnt <= '0;
    end else if (!modeEn) begin
      state <= ST_WAIT;
      busy  <= 1'b0;
      ackN  <= 1'b1;
      idle  <= 1'b0;
    end else if (modeRise && dreq) begin
      idle <= 1'b1;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (stb.capture) begin
            busy  <= 1'b1;
            state <= ST_DLY;
          end else if (idle && !dreq) begin
            idle <= 1'b0;
          end
        end
        ST_DLY: begin
          ackN   <= 1'b0;
          ackCnt <= ackLoad;
          state  <= ST_ACK;
        end
        ST_ACK: begin
          if (ackCnt <= ACK_W'(1)) begin
            ackN  <= 1'b1;
            state <= ST_REL;
          end else begin
            ackCnt <= ackCnt - ACK_W'(1);
          end
        end
        ST_REL: begin
          if (!dreq) begin
            busy  <= 1'b0;
            state <= ST_WAIT;
          end else begin
            idle  <= 1'b1;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!dreq) begin
            busy  <= 1'b0;
            idle  <= 1'b0;
            state <= ST_WAIT;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/pp_rx_datapath.sv
module pp_rx_datapath
  import pp_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACK_W = 8,
  parameter int ACK_RESET = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] padDataIn,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              idle,
  input  logic              autoFdSync,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] padDataOut,
  output logic [DATA_W-1:0] padDataOe,
  output logic              dreq,
  output logic [ACK_W-1:0]  ackWidth,
  output logic              select,
  output logic              pError,
  output logic              faultN
);

  localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(1) << CTRL_FAULTN;

  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] dirReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic [ACK_W-1:0]  timeReg;
  logic              dataRead;

  assign dataRead = regRd && (regAddr == ADDR_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
      dreq  <= 1'b0;
    end else if (stb.capture) begin
      rxReg <= padDataIn;
      dreq  <= 1'b1;
    end else if (dataRead) begin
      dreq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg   <= '0;
      dirReg  <= '0;
      ctrlReg <= CTRL_RESET;
      timeReg <= ACK_W'(ACK_RESET);
    end else if (regWr) begin
      unique case (regAddr)
        ADDR_DATA: txReg   <= regWdata;
        ADDR_DIR:  dirReg  <= regWdata;
        ADDR_CTRL: ctrlReg <= regWdata[CTRL_W-1:0];
        ADDR_TIME: timeReg <= regWdata[ACK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_DATA: regRdata = rxReg;
      ADDR_DIR:  regRdata = dirReg;
      ADDR_CTRL: regRdata = DATA_W'(ctrlReg);
      ADDR_TIME: regRdata = DATA_W'(timeReg);
      ADDR_STAT: regRdata = DATA_W'({dreq, idle, autoFdSync});
      default:   regRdata = '0;
    endcase
  end

  for (genvar b = 0; b < DATA_W; b++) begin : gPinDir
    assign padDataOe[b] = dirReg[b] & ~stb.forceIn;
  end

  assign padDataOut = txReg;
  assign ackWidth   = timeReg;
  assign select     = ctrlReg[CTRL_SELECT];
  assign pError     = ctrlReg[CTRL_PERROR];
  assign faultN     = ctrlReg[CTRL_FAULTN];

endmodule

// File: rtl/pp_rx_periph.sv
module pp_rx_periph
  import pp_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACK_W = 8,
  parameter int ACK_RESET = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEn,
  input  logic              strobeN,
  input  logic              selectInN,
  input  logic              autoFdN,
  input  logic [DATA_W-1:0] padDataIn,
  output logic [DATA_W-1:0] padDataOut,
  output logic [DATA_W-1:0] padDataOe,
  output logic              busy,
  output logic              ackN,
  output logic              select,
  output logic              pError,
  output logic              faultN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              dreq,
  output logic              idle
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] syncVec;
  logic [ACK_W-1:0]  ackWidth;
  dpStrobe_t         stb;

  pp_rx_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({autoFdN, selectInN, strobeN}),
    .syncOut(syncVec)
  );

  pp_rx_ctrl #(.ACK_W(ACK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeEn(modeEn),
    .strobeSync(syncVec[0]), .selSync(syncVec[1]),
    .dreq(dreq), .ackWidth(ackWidth), .stb(stb),
    .busy(busy), .ackN(ackN), .idle(idle)
  );

  pp_rx_datapath #(.DATA_W(DATA_W), .ACK_W(ACK_W), .ACK_RESET(ACK_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .padDataIn(padDataIn),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .idle(idle), .autoFdSync(syncVec[2]), .regRdata(regRdata),
    .padDataOut(padDataOut), .padDataOe(padDataOe), .dreq(dreq),
    .ackWidth(ackWidth), .select(select), .pError(pError), .faultN(faultN)
  );

endmodule

// File: rtl/pp_rx_periph_chk.sv
module pp_rx_periph_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeEn,
  input logic       busy,
  input logic       ackN,
  input logic       dreq,
  input logic       regRd,
  input logic [2:0] regAddr
);

  AST_ACK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> busy); // R4

  AST_BUSY_RISE_WITH_DREQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> dreq); // R2

  AST_ACK_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> $fell(ackN)); // R4

  AST_DREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dreq && !(regRd && regAddr == 3'd0)) |=> dreq); // R3

  AST_BUSY_DROP_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && modeEn && $past(modeEn)) |-> !dreq); // R6

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(modeEn) |-> (!busy && ackN)); // R13

endmodule

bind pp_rx_periph pp_rx_periph_chk u_chk (
  .clk(clk), .rstN(rstN), .modeEn(modeEn), .busy(busy), .ackN(ackN),
  .dreq(dreq), .regRd(regRd), .regAddr(regAddr)
);

// File: tb/sim_pp_rx_periph.sv
`timescale 1ns/1ps
module sim_pp_rx_periph;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeEn = 1'b0;
  logic       strobeN = 1'b1;
  logic       selectInN = 1'b1;
  logic       autoFdN = 1'b1;
  logic [7:0] padDataIn = 8'h00;
  logic [7:0] padDataOut, padDataOe, regRdata;
  logic       busy, ackN, select, pError, faultN, dreq, idle;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'h00;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pp_rx_periph u0 (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .strobeN(strobeN),
    .selectInN(selectInN), .autoFdN(autoFdN), .padDataIn(padDataIn),
    .padDataOut(padDataOut), .padDataOe(padDataOe), .busy(busy), .ackN(ackN),
    .select(select), .pError(pError), .faultN(faultN), .regWr(regWr),
    .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .dreq(dreq), .idle(idle)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mSt, mCnt, mAckW;
  bit mBusy, mAckN, mIdle, mDreq, mPrev;
  bit s1, s2, s3, e1, e2, f1, f2;
  byte unsigned mRx, mTx, mDir;
  bit [2:0] mCtl;

  always @(posedge clk) begin
    bit fall, cap, rdc;
    if (!rstN) begin
      mSt = 0; mCnt = 0; mAckW = 25; mBusy = 0; mAckN = 1; mIdle = 0; mDreq = 0;
      mPrev = 0; s1 = 1; s2 = 1; s3 = 1; e1 = 1; e2 = 1; f1 = 1; f2 = 1;
      mRx = 0; mTx = 0; mDir = 0; mCtl = 3'b100;
    end else begin
      fall = s3 && !s2;
      cap = modeEn && fall && !e2 && !mDreq && (mSt == 0);
      rdc = regRd && (regAddr == 3'd0);
      if (!modeEn) begin
        mSt = 0; mBusy = 0; mAckN = 1; mIdle = 0;
      end else if (!mPrev && mDreq) begin
        mIdle = 1;
      end else begin
        case (mSt)
          0: if (cap) begin mBusy = 1; mSt = 1; end
             else if (mIdle && !mDreq) mIdle = 0;
          1: begin mAckN = 0; mCnt = (mAckW == 0) ? 1 : mAckW; mSt = 2; end
          2: if (mCnt <= 1) begin mAckN = 1; mSt = 3; end else mCnt--;
          3: if (!mDreq) begin mBusy = 0; mSt = 0; end else begin mIdle = 1; mSt = 4; end
          default: if (!mDreq) begin mBusy = 0; mIdle = 0; mSt = 0; end
        endcase
      end
      if (cap) begin mRx = padDataIn; mDreq = 1; end
      else if (rdc) mDreq = 0;
      if (regWr) begin
        case (regAddr)
          3'd0: mTx = regWdata;
          3'd1: mDir = regWdata;
          3'd2: mCtl = regWdata[2:0];
          3'd3: mAckW = regWdata;
          default: ;
        endcase
      end
      s3 = s2; s2 = s1; s1 = strobeN;
      e2 = e1; e1 = selectInN;
      f2 = f1; f1 = autoFdN;
      mPrev = modeEn;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R2/R6 busy", busy, mBusy);
      check("R4/R5 ackN", ackN, mAckN);
      check("R3 dreq", dreq, mDreq);
      check("R6 idle", idle, mIdle);
      check("R1 padDataOe", padDataOe, (modeEn && !e2) ? 0 : mDir);
      check("R1 padDataOut", padDataOut, mTx);
      check("R11 select", select, mCtl[0]);
      check("R11 pError", pError, mCtl[1]);
      check("R11 faultN", faultN, mCtl[2]);
    end
  end

  // acknowledge width measurement
  int ackRun = 0;
  int ackLast = 0;
  always @(negedge clk) begin
    if (rstN && ackN == 1'b0) ackRun++;
    else if (ackRun > 0) begin ackLast = ackRun; ackRun = 0; end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    tick();
    regRd = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] b, input int lowCycles);
    padDataIn = b; strobeN = 1'b0;
    tick(lowCycles);
    strobeN = 1'b1;
    tick();
  endtask

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    tick(3);
    rstN = 1'b1;
    tick();
    // reset state
    check("R2 reset busy", busy, 0);
    check("R4 reset ackN", ackN, 1);
    check("R3 reset dreq", dreq, 0);
    check("R11 reset faultN", faultN, 1);
    regRead(3'd3, rd); check("R5 reset timing", rd, 25);
    regRead(3'd2, rd); check("R11 reset ctrl", rd, 8'h04);

    // status pins
    regWrite(3'd2, 8'h03);
    tick();
    check("R11 select", select, 1);
    check("R11 pError", pError, 1);
    check("R11 faultN", faultN, 0);

    // enter mode with nothing pending
    modeEn = 1'b1;
    tick(2);
    check("R13 entry no idle", idle, 0);

    // pin direction
    regWrite(3'd1, 8'hFF);
    regWrite(3'd0, 8'hA5);
    tick(2);
    check("R1 oe select high", padDataOe, 8'hFF);
    check("R1 data out", padDataOut, 8'hA5);
    selectInN = 1'b0;
    tick(3);
    check("R1 oe forced input", padDataOe, 8'h00);

    // capture with prompt read, width 4
    regWrite(3'd3, 8'd4);
    strobe(8'h3C, 3);
    regRead(3'd0, rd); check("R2 captured byte", rd, 8'h3C);
    tick(12);
    check("R5 ack width 4", ackLast, 4);
    check("R6 busy released", busy, 0);
    check("R6 no idle", idle, 0);

    // no read: idle stall, then ignored strobe, then drain
    strobe(8'h5A, 3);
    tick(12);
    check("R6 busy held", busy, 1);
    check("R6 idle set", idle, 1);
    strobe(8'h77, 3);
    tick(10);
    regRead(3'd4, rd); check("R12 status idle+dreq", rd & 8'h06, 8'h06);
    regRead(3'd0, rd); check("R8 byte kept", rd, 8'h5A);
    tick();
    check("R7 busy low after drain", busy, 0);
    check("R7 idle cleared", idle, 0);

    // select-in high: strobe ignored
    selectInN = 1'b1;
    tick(3);
    strobe(8'h11, 3);
    tick(10);
    check("R9 no dreq", dreq, 0);
    check("R9 no busy", busy, 0);
    selectInN = 1'b0;
    tick(3);

    // long strobe: read mid-pulse, no second capture
    padDataIn = 8'h22; strobeN = 1'b0;
    tick(14);
    regRead(3'd0, rd); check("R10 first byte", rd, 8'h22);
    padDataIn = 8'h99;
    tick(12);
    check("R10 no recapture", dreq, 0);
    check("R10 busy low", busy, 0);
    strobeN = 1'b1;
    tick(3);

    // autoFd is status only
    autoFdN = 1'b0;
    tick(3);
    regRead(3'd4, rd); check("R12 autoFd low", rd & 8'h01, 0);
    strobe(8'h66, 3);
    regRead(3'd0, rd); check("R12 handshake unaffected", rd, 8'h66);
    tick(12);
    check("R12 busy released", busy, 0);
    autoFdN = 1'b1;
    tick(3);
    regRead(3'd4, rd); check("R12 autoFd high", rd & 8'h01, 1);

    // leave and re-enter with a byte pending
    strobe(8'h44, 3);
    tick(12);
    modeEn = 1'b0;
    tick();
    check("R13 off busy", busy, 0);
    check("R13 off idle", idle, 0);
    check("R13 dreq kept", dreq, 1);
    modeEn = 1'b1;
    tick();
    check("R13 entry idle", idle, 1);
    regRead(3'd0, rd); check("R13 pending byte", rd, 8'h44);
    tick();
    check("R13 idle cleared", idle, 0);

    // zero width treated as one
    regWrite(3'd3, 8'd0);
    strobe(8'h81, 3);
    regRead(3'd0, rd);
    tick(8);
    check("R5 ack width zero", ackLast, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule